// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the status byte of a serial non-volatile memory and decides, byte by byte, whether a memory write may land in the array. It sits behind the serial command decoder. The decoder supplies single-cycle strobes for write-enable, write-disable, a status write with its data byte, and each completed memory data byte with its address. The block also samples the level of the write-protect pin. It returns the status byte for status reads and a per-byte write permit for the array.

Memory writes and status writes are both gated by a write-enable latch. A two-bit block-protect field fences off the top quarter, the top half or the whole of the address space. A status-lock bit makes the write-protect pin count. While the lock bit is set, the status register can change only while the pin is high. The latch stays set across any number of data bytes and status writes. It clears only on a write-disable strobe or on reset.

A protected byte is simply not permitted. The decoder keeps advancing its address counter as normal.

Top module: `srwp_unit`

## Requirements
- R1: After reset the status byte reads 00h.
- R2: A write-enable strobe sets bit 1 of the status byte (the enable latch) on the next cycle, and a write-disable strobe clears it. When both strobes arrive in the same cycle, the write-disable strobe wins.
- R3: While the enable latch is 0, the write permit stays low for every address, and a status write strobe leaves the status byte unchanged.
- R4: While the enable latch is 1, the permit for a data byte depends on the protect field in status bits 3:2. Value 00 protects nothing. Value 01 protects addresses whose two top bits are 11 (18000h to 1FFFFh). Value 10 protects addresses whose top bit is 1 (10000h to 1FFFFh). Value 11 protects every address.
- R5: With the enable latch at 1 and status bit 7 (the lock bit) at 0, a status write copies data bits 7, 3 and 2 into status bits 7, 3 and 2, whatever the level of the protect pin.
- R6: With the lock bit at 1, a status write changes status bits 7, 3 and 2 only if the protect pin is high in that cycle. While the pin is low, those bits are held.
- R7: Neither a status write nor any number of data-byte strobes changes the enable latch.
- R8: Status bits 0, 4, 5 and 6 always read 0, and status-write data in those bit positions and in bit 1 has no effect.
- R9: The write permit is combinational with the data-byte strobe. It is high only in a cycle where that strobe is high and the address is unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status write strobe, data valid this cycle |
| wrsr_data_i | input | 8 | Status write data byte |
| wp_i | input | 1 | Write-protect pin level |
| wr_byte_i | input | 1 | Memory data byte complete strobe |
| wr_addr_i | input | 17 | Address of that data byte |
| status_o | output | 8 | Status byte for status reads |
| wr_allow_o | output | 1 | Permit to store the current data byte |

## Verification
The checker assumes that each strobe lasts one cycle. It also assumes that a status write never coincides with a write-enable or write-disable strobe, so each status transition has a single cause. The random stimulus issues exactly one command per operation and holds the pin level steady across it. Only the directed case combining write-enable with write-disable raises two strobes together, and the checker treats that pair by priority. Address, data and pin values are drawn at random so that every protect region and every lock state is reached.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    typedef struct packed {
        logic       lock;    // status bit 7
        logic [1:0] prot;    // status bits 3:2
        logic       wel;     // status bit 1
    } sr_state_t;

    localparam int POS_WEL  = 1;
    localparam int POS_PLO  = 2;
    localparam int POS_PHI  = 3;
    localparam int POS_LOCK = 7;

    localparam logic [1:0] PROT_NONE    = 2'b00;
    localparam logic [1:0] PROT_QUARTER = 2'b01;
    localparam logic [1:0] PROT_HALF    = 2'b10;
    localparam logic [1:0] PROT_ALL     = 2'b11;

endpackage

// File: rtl/srwp_status_reg.sv
module srwp_status_reg
    import srwp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [DATA_W-1:0] wrsr_data_i,
    input  logic              wp_i,
    output sr_state_t         state_o
);

    sr_state_t state_d, state_q;
    logic      sr_open;

    always_comb begin
        state_d = state_q;
        sr_open = state_q.wel && (!state_q.lock || wp_i);
        if (wrsr_i && sr_open) begin
            state_d.lock = wrsr_data_i[POS_LOCK];
            state_d.prot = {wrsr_data_i[POS_PHI], wrsr_data_i[POS_PLO]};
        end
        if (wrdi_i) begin
            state_d.wel = 1'b0;
        end else if (wren_i) begin
            state_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/srwp_guard.sv
module srwp_guard
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              wel_i,
    input  logic [1:0]        prot_i,
    input  logic              wr_byte_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              allow_o
);

    localparam int TOP = ADDR_W - 1;

    logic in_half, in_quarter, fenced;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_half    = addr_i[TOP];
            assign in_quarter = addr_i[TOP] & addr_i[TOP-1];
        end else begin : g_narrow
            assign in_half    = addr_i[TOP];
            assign in_quarter = addr_i[TOP];
        end
    endgenerate

    always_comb begin
        case (prot_i)
            PROT_NONE:    fenced = 1'b0;
            PROT_QUARTER: fenced = in_quarter;
            PROT_HALF:    fenced = in_half;
            default:      fenced = 1'b1;
        endcase
        allow_o = wr_byte_i && wel_i && !fenced;
    end

endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [DATA_W-1:0] wrsr_data_i,
    input  logic              wp_i,
    input  logic              wr_byte_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [DATA_W-1:0] status_o,
    output logic              wr_allow_o
);

    sr_state_t sr_q;

    srwp_status_reg #(.DATA_W(DATA_W)) u_sreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wren_i      (wren_i),
        .wrdi_i      (wrdi_i),
        .wrsr_i      (wrsr_i),
        .wrsr_data_i (wrsr_data_i),
        .wp_i        (wp_i),
        .state_o     (sr_q)
    );

    srwp_guard #(.ADDR_W(ADDR_W)) u_guard (
        .wel_i     (sr_q.wel),
        .prot_i    (sr_q.prot),
        .wr_byte_i (wr_byte_i),
        .addr_i    (wr_addr_i),
        .allow_o   (wr_allow_o)
    );

    always_comb begin
        status_o           = '0;
        status_o[POS_WEL]  = sr_q.wel;
        status_o[POS_PLO]  = sr_q.prot[0];
        status_o[POS_PHI]  = sr_q.prot[1];
        status_o[POS_LOCK] = sr_q.lock;
    end

endmodule

// File: rtl/srwp_checker.sv
module srwp_checker #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wren_i,
    input logic              wrdi_i,
    input logic              wrsr_i,
    input logic [DATA_W-1:0] wrsr_data_i,
    input logic              wp_i,
    input logic              wr_byte_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] status_o,
    input logic              wr_allow_o
);

    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wren_i && !wrdi_i |=> status_o[1]);

    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_i |=> !status_o[1]);

    a_r3_no_permit_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> !wr_allow_o);

    a_r3_status_held_closed: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && !status_o[1] && !wren_i && !wrdi_i |=> $stable(status_o));

    a_r4_all_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b11 |-> !wr_allow_o);

    a_r5_open_update: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && status_o[1] && !status_o[7] |=>
            status_o[7] == $past(wrsr_data_i[7]) && status_o[3:2] == $past(wrsr_data_i[3:2]));

    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && status_o[7] && !wp_i |=> $stable(status_o[7:2]));

    a_r7_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !wren_i && !wrdi_i |=> $stable(status_o[1]));

    a_r9_permit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow_o |-> wr_byte_i);

endmodule

bind srwp_unit srwp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_srwp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .wrsr_i      (wrsr_i),
    .wrsr_data_i (wrsr_data_i),
    .wp_i        (wp_i),
    .wr_byte_i   (wr_byte_i),
    .wr_addr_i   (wr_addr_i),
    .status_o    (status_o),
    .wr_allow_o  (wr_allow_o)
);

// File: tb/test_srwp_unit.sv
module test_srwp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, wp_i = 1'b0, wr_byte_i = 1'b0;
    logic [7:0]  wrsr_data_i = '0;
    logic [16:0] wr_addr_i = '0;
    logic [7:0]  status_o;
    logic        wr_allow_o;

    int n_run = 0, n_fail = 0;
    bit m_wel = 0, m_lock = 0;
    bit [1:0] m_prot = 0;

    always #4 clk = ~clk;

    srwp_unit i_srwp_unit (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
        .wrsr_data_i(wrsr_data_i), .wp_i(wp_i), .wr_byte_i(wr_byte_i),
        .wr_addr_i(wr_addr_i), .status_o(status_o), .wr_allow_o(wr_allow_o)
    );

    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_prot, m_wel, 1'b0};
    endfunction

    function automatic bit exp_allow(input logic [16:0] a);
        bit fenced;
        case (m_prot)
            2'b00: fenced = 0;
            2'b01: fenced = a[16] & a[15];
            2'b10: fenced = a[16];
            default: fenced = 1;
        endcase
        return m_wel && !fenced;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a later negedge with status checked.
    task automatic op(input bit en, input bit dis, input bit sr, input bit wb,
                      input logic [7:0] d, input bit wp, input logic [16:0] a, input string req);
        wren_i = en; wrdi_i = dis; wrsr_i = sr; wr_byte_i = wb;
        wrsr_data_i = d; wp_i = wp; wr_addr_i = a;
        #2;
        if (wb) check8({req, " R4 R9 permit"}, {7'd0, wr_allow_o}, {7'd0, exp_allow(a)});
        else    check8("R9 idle permit", {7'd0, wr_allow_o}, 8'd0);
        @(posedge clk);
        if (sr && m_wel && (!m_lock || wp)) begin
            m_lock = d[7];
            m_prot = d[3:2];
        end
        if (dis) m_wel = 0;
        else if (en) m_wel = 1;
        @(negedge clk);
        wren_i = 0; wrdi_i = 0; wrsr_i = 0; wr_byte_i = 0;
        #1;
        check8({req, " status"}, status_o, exp_status());
    endtask

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check8("R1 reset", status_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 after release", status_o, 8'h00);

        // R3: closed latch blocks everything
        op(0, 0, 1, 0, 8'h8C, 1, '0, "R3 status write closed");
        op(0, 0, 0, 1, 8'h00, 0, 17'h00010, "R3 data closed");
        // R2: both strobes, disable wins
        op(1, 1, 0, 0, 8'h00, 0, '0, "R2 both strobes");
        op(1, 0, 0, 0, 8'h00, 0, '0, "R2 enable");
        // R8: junk bits ignored, R5 update with wp low
        op(0, 0, 1, 0, 8'h73, 0, '0, "R8 R5 reserved bits");
        op(0, 0, 1, 0, 8'h04, 0, '0, "R5 quarter");
        op(0, 0, 0, 1, 8'h00, 0, 17'h17FFF, "R4 below quarter");
        op(0, 0, 0, 1, 8'h00, 0, 17'h18000, "R4 quarter edge");
        op(0, 0, 1, 0, 8'h08, 0, '0, "R5 half");
        op(0, 0, 0, 1, 8'h00, 0, 17'h0FFFF, "R4 below half");
        op(0, 0, 0, 1, 8'h00, 0, 17'h10000, "R4 half edge");
        // R6: lock set, pin low holds, pin high releases
        op(0, 0, 1, 0, 8'h8C, 0, '0, "R6 set lock");
        op(0, 0, 1, 0, 8'h00, 0, '0, "R6 locked pin low");
        op(0, 0, 0, 1, 8'h00, 0, 17'h00000, "R4 all fenced");
        op(0, 0, 1, 0, 8'h00, 1, '0, "R6 locked pin high");
        // R7: latch survives data bytes and status writes
        op(0, 0, 0, 1, 8'h00, 0, 17'h1FFFF, "R7 data keeps latch");
        op(0, 0, 1, 0, 8'h00, 1, '0, "R7 status write keeps latch");
        op(0, 1, 0, 0, 8'h00, 0, '0, "R2 disable");

        for (int i = 0; i < 600; i++) begin
            int k = $urandom % 7;
            logic [7:0]  d = 8'($urandom);
            logic [16:0] a = 17'($urandom);
            bit wp = bit'($urandom % 2);
            case (k)
                0:       op(1, 0, 0, 0, d, wp, a, "R2 rnd enable");
                1:       op(0, 1, 0, 0, d, wp, a, "R2 rnd disable");
                2, 3:    op(0, 0, 1, 0, d, wp, a, "R5 R6 rnd status write");
                default: op(0, 0, 0, 1, d, wp, a, "R4 R7 rnd data");
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule